// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the part of a small 8-bit CPU core that takes interrupts and runs the matching return instructions. When an instruction finishes, the block checks the pending requests. A non-maskable request is latched on its rising edge and is always taken. A maskable request is taken only while the master enable flag is set. When a request is taken, the block saves the program counter and the status word as a three-byte frame on a byte stack that grows downward. It clears the master enable flag and then hands the core the new stack pointer, the unchanged status word and the vector address for the source that was taken.

The core signals a decoded return with one of two strobes. The block then reads the frame back, moves the stack pointer up by three and returns the restored registers with a one-cycle done strobe. A maskable return always sets the master enable flag again. A non-maskable return copies a one-bit record instead. That record holds whether the enable flag was set when the non-maskable request was taken, and it is cleared when software writes 0 to the flag during service. The done cycle of a return also counts as an instruction's final cycle, so a request that is already pending starts a new entry in the very next cycle.

Top module: `intr_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `seq_done`, `mem_we`, `mem_re` and `ime` are all 0, and an idle block drives no stack access.
- R2: Requests are sampled only in an idle cycle where `instr_last` is 1 and no return strobe is present. A maskable request (`mi_req` level) is taken only if `ime` is 1 at that point.
- R3: A rising edge on `nmi_req` latches a pending request that is taken at the next sampling point whatever `ime` is. It wins over a maskable request sampled at the same point. Holding `nmi_req` high does not raise a second request.
- R4: An entry starts in the cycle after sampling and makes three stack writes in three cycles: PC bits 7:0 at SP, PC bits 15:8 at SP-1, PSW at SP-2. The next cycle is the done cycle: `seq_done`=1, `pc_out` is the vector (`MI_VEC` for maskable, `NMI_VEC` for non-maskable), `psw_out` is the saved PSW and `sp_out` is SP-3.
- R5: Taking a request clears `ime`, so `ime` reads 0 from the first stack write onward. Taking a non-maskable request stores the value `ime` had at that moment into the enable record.
- R6: A `ret_mi` or `ret_nmi` pulse in an idle cycle starts a return, even if `instr_last` is also high. The return makes three reads in three cycles: PSW from SP+1, PC bits 15:8 from SP+2, PC bits 7:0 from SP+3. The done cycle then shows the restored PC and PSW and `sp_out`=SP+3.
- R7: After a `ret_mi` return, `ime` is 1 in the cycle after the done cycle.
- R8: After a `ret_nmi` return, `ime` in the cycle after the done cycle equals the enable record. Any software write of 0 to `ime` after the entry clears the record.
- R9: `ime_wr_en` loads `ime_wr_data` into `ime` in an idle cycle, unless a request is taken in that same cycle. The write is ignored while the block is busy.
- R10: The done cycle of a return is a sampling point that uses the restored `ime`. If a request is taken there, its first stack write comes in the very next cycle at the restored SP, and the frame holds the restored PC and PSW.
- R11: `mem_we` and `mem_re` are never 1 together, and `seq_done` is never 1 in two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_last | input | 1 | Final cycle of the current instruction (sampling point) |
| mi_req | input | 1 | Maskable interrupt request level |
| nmi_req | input | 1 | Non-maskable interrupt request, taken on its rising edge |
| ret_mi | input | 1 | Decoded maskable-return strobe |
| ret_nmi | input | 1 | Decoded non-maskable-return strobe |
| ime_wr_en | input | 1 | Software write of the master enable flag |
| ime_wr_data | input | 1 | Value for the software write |
| pc_in | input | 16 | Current program counter |
| psw_in | input | 8 | Current program status word |
| sp_in | input | 16 | Current stack pointer |
| mem_we | output | 1 | Stack write enable |
| mem_re | output | 1 | Stack read enable |
| mem_addr | output | 16 | Stack byte address |
| mem_wdata | output | 8 | Stack write data |
| mem_rdata | input | 8 | Stack read data, valid in the same cycle as `mem_re` |
| seq_done | output | 1 | One-cycle done strobe; register outputs are valid in this cycle |
| busy | output | 1 | A sequence is in progress |
| ime | output | 1 | Master enable flag |
| pc_out | output | 16 | New program counter in the done cycle |
| psw_out | output | 8 | New status word in the done cycle |
| sp_out | output | 16 | New stack pointer in the done cycle |

## Verification
A table of frames drives entries from three kinds of source: a maskable request with the flag set, a non-maskable request with the flag set, and a non-maskable request with the flag clear. Each entry is followed by its own return. Because the table mixes source kinds, the two vectors and the two rules for restoring the flag can each be told apart. One frame sits where the stack wraps, which separates correct modular address arithmetic from arithmetic that truncates. Directed patterns then cover the cases where ordering matters: maskable and non-maskable requests pending together, a request held high across a sampling point, a non-maskable request nested inside a maskable service, a software clear followed by a re-enable before the non-maskable return, a write that lands while the block is busy, and a maskable request still pending when its return finishes. These patterns tell priority apart from arrival order, edge latching from level sensing, and the enable record from the live flag. They also show whether the sampling point at the end of a return sees the restored flag.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;

    // Sequencer phase
    typedef enum logic [2:0] {
        S_IDLE,
        S_PUSH0,
        S_PUSH1,
        S_PUSH2,
        S_POP0,
        S_POP1,
        S_POP2,
        S_FIN
    } seq_st_e;

    // What the current sequence is doing
    typedef enum logic [1:0] {
        K_MI,
        K_NMI,
        K_RETI,
        K_RETN
    } seq_kind_e;

endpackage

// File: rtl/intr_nmi_latch.sv
module intr_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_req,
    input  logic clr,
    output logic pend
);

    typedef struct packed {
        logic prev;
        logic pend;
    } latch_t;

    latch_t l_d, l_q;

    always_comb begin
        l_d      = l_q;
        l_d.prev = nmi_req;
        if (clr) begin
            l_d.pend = 1'b0;
        end
        // a fresh edge survives a clear in the same cycle
        if (nmi_req && !l_q.prev) begin
            l_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_q <= '0;
        end else begin
            l_q <= l_d;
        end
    end

    assign pend = l_q.pend;

endmodule

// File: rtl/intr_arb.sv
module intr_arb (
    input  logic sample,
    input  logic ime_now,
    input  logic mi_req,
    input  logic nmi_pend,
    output logic take,
    output logic take_nmi
);

    always_comb begin
        take_nmi = sample && nmi_pend;
        take     = take_nmi || (sample && mi_req && ime_now);
    end

endmodule

// File: rtl/intr_frame_port.sv
module intr_frame_port
    import intr_seq_pkg::*;
#(
    parameter int SP_W   = 16,
    parameter int DATA_W = 8,
    localparam int PC_W  = 2 * DATA_W
) (
    input  seq_st_e             st,
    input  logic [SP_W-1:0]     sp,
    input  logic [PC_W-1:0]     pc,
    input  logic [DATA_W-1:0]   psw,
    output logic                we,
    output logic                re,
    output logic [SP_W-1:0]     addr,
    output logic [DATA_W-1:0]   wdata
);

    always_comb begin
        we    = 1'b0;
        re    = 1'b0;
        addr  = sp;
        wdata = '0;
        case (st)
            S_PUSH0: begin
                we    = 1'b1;
                addr  = sp;
                wdata = pc[DATA_W-1:0];
            end
            S_PUSH1: begin
                we    = 1'b1;
                addr  = sp - SP_W'(1);
                wdata = pc[PC_W-1:DATA_W];
            end
            S_PUSH2: begin
                we    = 1'b1;
                addr  = sp - SP_W'(2);
                wdata = psw;
            end
            S_POP0: begin
                re   = 1'b1;
                addr = sp + SP_W'(1);
            end
            S_POP1: begin
                re   = 1'b1;
                addr = sp + SP_W'(2);
            end
            S_POP2: begin
                re   = 1'b1;
                addr = sp + SP_W'(3);
            end
            default: begin
                we = 1'b0;
                re = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/intr_seq.sv
module intr_seq
    import intr_seq_pkg::*;
#(
    parameter int          SP_W    = 16,
    parameter int          DATA_W  = 8,
    parameter int unsigned MI_VEC  = 32'h0040,
    parameter int unsigned NMI_VEC = 32'h0020,
    localparam int         PC_W    = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_last,
    input  logic              mi_req,
    input  logic              nmi_req,
    input  logic              ret_mi,
    input  logic              ret_nmi,
    input  logic              ime_wr_en,
    input  logic              ime_wr_data,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [DATA_W-1:0] psw_in,
    input  logic [SP_W-1:0]   sp_in,
    output logic              mem_we,
    output logic              mem_re,
    output logic [SP_W-1:0]   mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              seq_done,
    output logic              busy,
    output logic              ime,
    output logic [PC_W-1:0]   pc_out,
    output logic [DATA_W-1:0] psw_out,
    output logic [SP_W-1:0]   sp_out
);

    localparam int FRAME_BYTES = 3;
    localparam logic [PC_W-1:0] MI_ADDR  = PC_W'(MI_VEC);
    localparam logic [PC_W-1:0] NMI_ADDR = PC_W'(NMI_VEC);

    typedef struct packed {
        seq_st_e             st;
        seq_kind_e           kind;
        logic                ime;
        logic                rec;
        logic [SP_W-1:0]     sp;
        logic [PC_W-1:0]     pc;
        logic [DATA_W-1:0]   psw;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic is_ret_fin;
    logic fin_ime;
    logic ret_req;
    logic sample;
    logic ime_now;
    logic take;
    logic take_nmi;
    logic nmi_pend;

    // ---------------- sampling point and arbitration ----------------
    always_comb begin
        ret_req    = ret_mi || ret_nmi;
        is_ret_fin = (r_q.st == S_FIN) &&
                     ((r_q.kind == K_RETI) || (r_q.kind == K_RETN));
        fin_ime    = (r_q.kind == K_RETI) ? 1'b1 : r_q.rec;
        sample     = ((r_q.st == S_IDLE) && instr_last && !ret_req) || is_ret_fin;
        ime_now    = is_ret_fin ? fin_ime : r_q.ime;
    end

    intr_nmi_latch u_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .nmi_req (nmi_req),
        .clr     (take_nmi),
        .pend    (nmi_pend)
    );

    intr_arb u_arb (
        .sample   (sample),
        .ime_now  (ime_now),
        .mi_req   (mi_req),
        .nmi_pend (nmi_pend),
        .take     (take),
        .take_nmi (take_nmi)
    );

    // ---------------- next-state logic ----------------
    always_comb begin
        r_d = r_q;
        case (r_q.st)
            S_IDLE: begin
                if (ret_req) begin
                    r_d.st   = S_POP0;
                    r_d.sp   = sp_in;
                    r_d.kind = ret_nmi ? K_RETN : K_RETI;
                end else if (take) begin
                    r_d.st   = S_PUSH0;
                    r_d.sp   = sp_in;
                    r_d.pc   = pc_in;
                    r_d.psw  = psw_in;
                    r_d.kind = take_nmi ? K_NMI : K_MI;
                    if (take_nmi) begin
                        r_d.rec = r_q.ime;
                    end
                    r_d.ime  = 1'b0;
                end else if (ime_wr_en) begin
                    r_d.ime = ime_wr_data;
                    if (!ime_wr_data) begin
                        r_d.rec = 1'b0;
                    end
                end
            end
            S_PUSH0: r_d.st = S_PUSH1;
            S_PUSH1: r_d.st = S_PUSH2;
            S_PUSH2: begin
                r_d.st = S_FIN;
                r_d.sp = r_q.sp - SP_W'(FRAME_BYTES);
            end
            S_POP0: begin
                r_d.st  = S_POP1;
                r_d.psw = mem_rdata;
            end
            S_POP1: begin
                r_d.st               = S_POP2;
                r_d.pc[PC_W-1:DATA_W] = mem_rdata;
            end
            S_POP2: begin
                r_d.st               = S_FIN;
                r_d.pc[DATA_W-1:0]   = mem_rdata;
                r_d.sp               = r_q.sp + SP_W'(FRAME_BYTES);
            end
            S_FIN: begin
                r_d.st = S_IDLE;
                if (is_ret_fin) begin
                    r_d.ime = fin_ime;
                    if (take) begin
                        // back-to-back entry from the restored registers
                        r_d.st   = S_PUSH0;
                        r_d.kind = take_nmi ? K_NMI : K_MI;
                        if (take_nmi) begin
                            r_d.rec = fin_ime;
                        end
                        r_d.ime  = 1'b0;
                    end
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, kind: K_MI, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    // ---------------- stack port ----------------
    intr_frame_port #(
        .SP_W   (SP_W),
        .DATA_W (DATA_W)
    ) u_port (
        .st    (r_q.st),
        .sp    (r_q.sp),
        .pc    (r_q.pc),
        .psw   (r_q.psw),
        .we    (mem_we),
        .re    (mem_re),
        .addr  (mem_addr),
        .wdata (mem_wdata)
    );

    // ---------------- register outputs ----------------
    always_comb begin
        seq_done = (r_q.st == S_FIN);
        busy     = (r_q.st != S_IDLE);
        ime      = r_q.ime;
        psw_out  = r_q.psw;
        sp_out   = r_q.sp;
        case (r_q.kind)
            K_MI:    pc_out = MI_ADDR;
            K_NMI:   pc_out = NMI_ADDR;
            default: pc_out = r_q.pc;
        endcase
    end

endmodule

// File: rtl/intr_seq_chk.sv
module intr_seq_chk #(
    parameter int SP_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mem_we,
    input logic            mem_re,
    input logic [SP_W-1:0] mem_addr,
    input logic            seq_done,
    input logic            busy,
    input logic            ime
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_re && !seq_done));                  // R1

    AST_PUSH_DESC: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == ($past(mem_addr) - SP_W'(1)))); // R4

    AST_PUSH_IME_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !ime);                                              // R5

    AST_POP_ASC: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && $past(mem_re)) |-> (mem_addr == ($past(mem_addr) + SP_W'(1)))); // R6

    AST_ACCESS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));                                          // R11

    AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done);                                       // R11

endmodule

bind intr_seq intr_seq_chk #(.SP_W(SP_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .mem_addr (mem_addr),
    .seq_done (seq_done),
    .busy     (busy),
    .ime      (ime)
);

// File: tb/intr_seq_tb.sv
`timescale 1ns/1ps
module intr_seq_tb;

    localparam int unsigned MI_V  = 32'h0040;
    localparam int unsigned NMI_V = 32'h0020;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_last = 1'b0, mi_req = 1'b0, nmi_req = 1'b0;
    logic        ret_mi = 1'b0, ret_nmi = 1'b0;
    logic        ime_wr_en = 1'b0, ime_wr_data = 1'b0;
    logic [15:0] pc_in = '0;
    logic [7:0]  psw_in = '0;
    logic [15:0] sp_in = '0;
    logic        mem_we, mem_re, seq_done, busy, ime;
    logic [15:0] mem_addr, pc_out, sp_out;
    logic [7:0]  mem_wdata, mem_rdata, psw_out;

    logic [7:0]  mem [0:255];
    int          n_chk = 0;
    int          n_fail = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    assign mem_rdata = mem[mem_addr[7:0]];

    intr_seq #(.MI_VEC(MI_V), .NMI_VEC(NMI_V)) u_dut (
        .clk(clk), .rst_n(rst_n), .instr_last(instr_last), .mi_req(mi_req),
        .nmi_req(nmi_req), .ret_mi(ret_mi), .ret_nmi(ret_nmi),
        .ime_wr_en(ime_wr_en), .ime_wr_data(ime_wr_data),
        .pc_in(pc_in), .psw_in(psw_in), .sp_in(sp_in),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .seq_done(seq_done), .busy(busy), .ime(ime),
        .pc_out(pc_out), .psw_out(psw_out), .sp_out(sp_out)
    );

    // kind[41:40] 0: maskable, ime=1  1: nmi, ime=1  2: nmi, ime=0 | sp | pc | psw
    localparam logic [41:0] TBL [4] = '{
        {2'd0, 16'h00F0, 16'h1234, 8'hA5},
        {2'd1, 16'h00E8, 16'hBEEF, 8'h3C},
        {2'd2, 16'h0080, 16'h0456, 8'h81},
        {2'd0, 16'h0001, 16'hFFFE, 8'h00}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_ime(input logic v);
        @(negedge clk); ime_wr_en = 1'b1; ime_wr_data = v;
        @(negedge clk); ime_wr_en = 1'b0;
    endtask

    task automatic nmi_pulse();
        @(negedge clk); nmi_req = 1'b1;
        @(negedge clk); nmi_req = 1'b0;
    endtask

    // ends at the negedge of the done cycle
    task automatic do_entry(input logic [15:0] pc, input logic [7:0] psw, input logic [15:0] sp);
        @(negedge clk); pc_in = pc; psw_in = psw; sp_in = sp; instr_last = 1'b1;
        @(negedge clk); instr_last = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_return(input logic is_nmi, input logic [15:0] sp);
        @(negedge clk); sp_in = sp; pc_in = 16'hDEAD; psw_in = 8'hEE;
        ret_nmi = is_nmi; ret_mi = !is_nmi;
        @(negedge clk); ret_nmi = 1'b0; ret_mi = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        // R1 reset state
        check("R1 busy", 32'(busy), 0);
        check("R1 ime", 32'(ime), 0);
        check("R1 seq_done", 32'(seq_done), 0);
        check("R1 mem_we", 32'(mem_we), 0);

        // R2 masked request not taken
        mi_req = 1'b1;
        do_entry(16'h1111, 8'h11, 16'h00F0);
        check("R2 masked mi", 32'(busy), 0);
        // R2 no sampling without instr_last
        set_ime(1'b1);
        repeat (3) step();
        check("R2 no instr_last", 32'(busy), 0);
        mi_req = 1'b0;

        // table walk: R4 R5 R6 R7 R8
        for (int i = 0; i < 4; i++) begin
            logic [1:0]  k;
            logic [15:0] sp, pc, vec;
            logic [7:0]  psw;
            k   = TBL[i][41:40];
            sp  = TBL[i][39:24];
            pc  = TBL[i][23:8];
            psw = TBL[i][7:0];
            vec = (k == 2'd0) ? 16'(MI_V) : 16'(NMI_V);
            set_ime(k != 2'd2);
            if (k == 2'd0) mi_req = 1'b1;
            else nmi_pulse();
            do_entry(pc, psw, sp);
            mi_req = 1'b0;
            check("R4 done", 32'(seq_done), 1);
            check("R4 vector", 32'(pc_out), 32'(vec));
            check("R4 sp", 32'(sp_out), 32'(16'(sp - 16'd3)));
            check("R4 psw", 32'(psw_out), 32'(psw));
            check("R4 pc lo byte", 32'(mem[sp[7:0]]), 32'(pc[7:0]));
            check("R4 pc hi byte", 32'(mem[8'(sp[7:0] - 8'd1)]), 32'(pc[15:8]));
            check("R4 psw byte", 32'(mem[8'(sp[7:0] - 8'd2)]), 32'(psw));
            check("R5 ime cleared", 32'(ime), 0);
            step();
            check("R11 done single", 32'(seq_done), 0);
            do_return(k != 2'd0, 16'(sp - 16'd3));
            check("R6 done", 32'(seq_done), 1);
            check("R6 pc", 32'(pc_out), 32'(pc));
            check("R6 psw", 32'(psw_out), 32'(psw));
            check("R6 sp", 32'(sp_out), 32'(sp));
            step();
            check((k == 2'd0) ? "R7 ime" : "R8 ime", 32'(ime), (k == 2'd2) ? 0 : 1);
        end

        // R3 priority and level hold
        set_ime(1'b1);
        mi_req = 1'b1;
        @(negedge clk); nmi_req = 1'b1;
        do_entry(16'h0777, 8'h07, 16'h00D0);
        mi_req = 1'b0;
        check("R3 nmi wins", 32'(pc_out), NMI_V);
        step();
        do_return(1'b1, 16'h00CD);
        step();
        check("R8 nmi from enabled", 32'(ime), 1);
        @(negedge clk); instr_last = 1'b1;
        @(negedge clk); instr_last = 1'b0;
        check("R3 level no retrigger", 32'(busy), 0);
        nmi_req = 1'b0;

        // nested: nmi inside maskable service
        set_ime(1'b1);
        mi_req = 1'b1;
        do_entry(16'h1234, 8'h5A, 16'h00F0);
        mi_req = 1'b0;
        step();
        nmi_pulse();
        do_entry(16'h0045, 8'h11, 16'h00ED);
        check("R3 nested nmi vec", 32'(pc_out), NMI_V);
        check("R4 nested sp", 32'(sp_out), 32'h00EA);
        step();
        do_return(1'b1, 16'h00EA);
        check("R6 nested pc", 32'(pc_out), 32'h0045);
        check("R6 nested sp", 32'(sp_out), 32'h00ED);
        step();
        check("R8 nested ime stays 0", 32'(ime), 0);
        do_return(1'b0, 16'h00ED);
        check("R6 outer pc", 32'(pc_out), 32'h1234);
        check("R6 outer psw", 32'(psw_out), 32'h5A);
        step();
        check("R7 outer ime", 32'(ime), 1);

        // software clear of the record, then re-enable
        nmi_pulse();
        do_entry(16'h0300, 8'h30, 16'h00E0);
        step();
        set_ime(1'b0);
        set_ime(1'b1);
        check("R9 sw write", 32'(ime), 1);
        do_return(1'b1, 16'h00DD);
        step();
        check("R8 record cleared", 32'(ime), 0);

        // write ignored while busy
        set_ime(1'b1);
        mi_req = 1'b1;
        @(negedge clk); pc_in = 16'h0500; psw_in = 8'h50; sp_in = 16'h00B0; instr_last = 1'b1;
        @(negedge clk); instr_last = 1'b0; mi_req = 1'b0; ime_wr_en = 1'b1; ime_wr_data = 1'b1;
        @(negedge clk); ime_wr_en = 1'b0;
        repeat (2) step();
        check("R9 busy write done", 32'(seq_done), 1);
        check("R9 busy write ignored", 32'(ime), 0);
        step();
        do_return(1'b0, 16'h00AD);
        step();

        // back-to-back
        set_ime(1'b1);
        mi_req = 1'b1;
        do_entry(16'h2222, 8'h33, 16'h00C0);
        step();
        do_return(1'b0, 16'h00BD);
        check("R10 ret done", 32'(seq_done), 1);
        check("R10 ret pc", 32'(pc_out), 32'h2222);
        step();
        mi_req = 1'b0;
        check("R10 immediate push", 32'(mem_we), 1);
        check("R10 push addr", 32'(mem_addr), 32'h00C0);
        check("R10 push data", 32'(mem_wdata), 32'h22);
        check("R10 ime cleared", 32'(ime), 0);
        repeat (3) step();
        check("R10 vector", 32'(pc_out), MI_V);
        check("R10 sp", 32'(sp_out), 32'h00BD);
        check("R10 psw", 32'(psw_out), 32'h33);
        step();
        do_return(1'b0, 16'h00BD);
        step();
        check("R7 final ime", 32'(ime), 1);

        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule